// File: doc/BRIEF.md
# Secure Region Address Filter

This block sits on the path from a bus requester to an external DRAM port and decides, for every access, whether the access may reach memory. Each access carries an address, a write flag and a non-secure attribute. The attribute tells whether the requester runs in the secure world or the non-secure world. The filter compares the address against a parameterised set of programmable regions. Each region has a page-aligned base, a length in 4 KB pages, an enable bit and a secure bit. From the result it either forwards the access to memory in the same cycle or answers it at once with an error, in which case nothing is driven to memory.

A secure requester may reach any address. A non-secure requester is forwarded only when the winning region is enabled and marked non-secure. The winning region is the highest-numbered enabled region that contains the address. An address outside every enabled region counts as secure. The region table is programmed through a small configuration port. Any requester may read that port, but only secure writers can change it. A non-secure write is refused with an error and changes nothing.

Top module: `sraf_top`

## Requirements
- R1: After reset every region reads back as base 0, size 0 and control 0, so every non-secure access is refused and every secure access is forwarded.
- R2: A secure access (up_ns=0) is always forwarded in the cycle it is presented. mem_req follows up_req, and mem_addr, mem_write and mem_wdata equal the upstream values. up_ack equals mem_ack, and up_rdata carries mem_rdata.
- R3: A non-secure access whose winning region is enabled with its secure bit clear is forwarded exactly as in R2.
- R4: A non-secure access whose winning region is secure is refused in the same cycle. up_err is 1, mem_req is 0, up_ack is 0 and up_rdata is 0.
- R5: A non-secure access that falls in no enabled region is refused as in R4.
- R6: When enabled regions overlap, the highest-numbered one decides. A region whose enable bit is 0 takes no part in the decision.
- R7: Region i covers pages base..base+size-1, where page = address bits [ADDR_W-1:12]. Address bits [11:0] do not affect matching, and a region of size 0 matches no address.
- R8: Config address = {region index, select[1:0]}. Select 0 holds the base page, select 1 the size in pages, and select 2 the control word, with bit 0 as enable and bit 1 as secure. Select 3 reads 0. A write with cfg_ns=0 takes effect at the next clock edge. cfg_rdata returns the addressed field in the same cycle while cfg_valid is 1, and is 0 otherwise.
- R9: A configuration write with cfg_ns=1 raises cfg_err in that cycle and leaves every region field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Upstream access request |
| up_addr | input | ADDR_W | Upstream byte address |
| up_write | input | 1 | 1 = write, 0 = read |
| up_ns | input | 1 | 1 = non-secure requester |
| up_wdata | input | DATA_W | Upstream write data |
| up_ack | output | 1 | Access completed by memory |
| up_err | output | 1 | Access refused |
| up_rdata | output | DATA_W | Read data to requester |
| mem_req | output | 1 | Request to DRAM port |
| mem_addr | output | ADDR_W | Address to DRAM port |
| mem_write | output | 1 | Write flag to DRAM port |
| mem_wdata | output | DATA_W | Write data to DRAM port |
| mem_ack | input | 1 | DRAM completion |
| mem_rdata | input | DATA_W | DRAM read data |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 = configuration write |
| cfg_ns | input | 1 | 1 = non-secure configuration writer |
| cfg_addr | input | IDX_W+2 | Region index and field select |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Configuration read data |
| cfg_err | output | 1 | Configuration write refused |

## Verification
Several properties are checked on every cycle. A refused access never raises mem_req or up_ack. A secure request always reaches memory. A forwarded non-secure access always has an enabled, non-secure winning region, and that winner is itself enabled. A non-secure configuration write leaves the whole region table stable. The address arithmetic needs directed scenarios against the bench's reference model: the first and last byte of a region, the page just past its end, and zero-size regions. So do the overlap orderings, where a higher region overrides a lower one or is skipped while disabled, and the readback that shows a refused write left the table as it was.

// File: rtl/sraf_pkg.sv
package sraf_pkg;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_RSVD = 2'd3
  } cfg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SEC_BIT = 1;

  // True when page lies inside [base, base + npages).
  function automatic logic page_in_region(input logic [63:0] page,
                                          input logic [63:0] base,
                                          input logic [63:0] npages);
    return (page >= base) && ((page - base) < npages);
  endfunction

endpackage

// File: rtl/sraf_cfg_regs.sv
module sraf_cfg_regs #(
  parameter int N      = 4,
  parameter int PN_W   = 20,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic              cfg_ns,
  input  logic [IDX_W+1:0]  cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_err,
  output logic              cfg_wr_ok,
  output logic [N*PN_W-1:0] base_flat,
  output logic [N*PN_W-1:0] size_flat,
  output logic [N-1:0]      en_vec,
  output logic [N-1:0]      sec_vec
);
  import sraf_pkg::*;

  logic [IDX_W-1:0] idx;
  cfg_sel_e         sel;
  logic             unused_wdata;

  assign idx          = cfg_addr[IDX_W+1:2];
  assign sel          = cfg_sel_e'(cfg_addr[1:0]);
  assign cfg_err      = cfg_valid & cfg_write & cfg_ns;
  assign cfg_wr_ok    = cfg_valid & cfg_write & ~cfg_ns;
  assign unused_wdata = ^cfg_wdata;

  for (genvar g = 0; g < N; g++) begin : g_region
    logic hit_idx;
    assign hit_idx = (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_flat[g*PN_W +: PN_W] <= '0;
        size_flat[g*PN_W +: PN_W] <= '0;
        en_vec[g]                 <= 1'b0;
        sec_vec[g]                <= 1'b0;
      end else if (cfg_wr_ok && hit_idx) begin
        case (sel)
          SEL_BASE: base_flat[g*PN_W +: PN_W] <= cfg_wdata[PN_W-1:0];
          SEL_SIZE: size_flat[g*PN_W +: PN_W] <= cfg_wdata[PN_W-1:0];
          SEL_CTRL: begin
            en_vec[g]  <= cfg_wdata[CTRL_EN_BIT];
            sec_vec[g] <= cfg_wdata[CTRL_SEC_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_valid) begin
      for (int i = 0; i < N; i++) begin
        if (idx == IDX_W'(i)) begin
          case (sel)
            SEL_BASE: cfg_rdata = DATA_W'(base_flat[i*PN_W +: PN_W]);
            SEL_SIZE: cfg_rdata = DATA_W'(size_flat[i*PN_W +: PN_W]);
            SEL_CTRL: cfg_rdata = DATA_W'({sec_vec[i], en_vec[i]});
            default:  cfg_rdata = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/sraf_region_match.sv
module sraf_region_match #(
  parameter int N     = 4,
  parameter int PN_W  = 20,
  parameter int IDX_W = 2
) (
  input  logic [PN_W-1:0]   page,
  input  logic [N*PN_W-1:0] base_flat,
  input  logic [N*PN_W-1:0] size_flat,
  input  logic [N-1:0]      en_vec,
  input  logic [N-1:0]      sec_vec,
  output logic              win_hit,
  output logic [IDX_W-1:0]  win_idx,
  output logic              win_secure
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit_vec[g] = en_vec[g] &
      sraf_pkg::page_in_region(64'(page),
                               64'(base_flat[g*PN_W +: PN_W]),
                               64'(size_flat[g*PN_W +: PN_W]));
  end

  // Ascending scan: the last hit, i.e. the highest index, wins.
  always_comb begin
    win_hit    = 1'b0;
    win_idx    = '0;
    win_secure = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        win_hit    = 1'b1;
        win_idx    = IDX_W'(i);
        win_secure = sec_vec[i];
      end
    end
  end

endmodule

// File: rtl/sraf_perm.sv
module sraf_perm (
  input  logic up_req,
  input  logic up_ns,
  input  logic win_hit,
  input  logic win_secure,
  output logic fwd,
  output logic blk
);
  logic permit;

  // Unmapped addresses count as secure.
  assign permit = ~up_ns | (win_hit & ~win_secure);
  assign fwd    = up_req & permit;
  assign blk    = up_req & ~permit;

endmodule

// File: rtl/sraf_top.sv
module sraf_top #(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int PAGE_BITS   = 12,
  localparam int PN_W       = ADDR_W - PAGE_BITS,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_write,
  input  logic              up_ns,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_ack,
  output logic              up_err,
  output logic [DATA_W-1:0] up_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic              cfg_ns,
  input  logic [IDX_W+1:0]  cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_err
);
  logic [NUM_REGIONS*PN_W-1:0] base_flat;
  logic [NUM_REGIONS*PN_W-1:0] size_flat;
  logic [NUM_REGIONS-1:0]      en_vec;
  logic [NUM_REGIONS-1:0]      sec_vec;
  logic                        cfg_wr_ok;
  logic                        win_hit;
  logic [IDX_W-1:0]            win_idx;
  logic                        win_secure;
  logic                        acc_fwd;
  logic                        acc_blk;
  logic                        unused_obs;

  sraf_cfg_regs #(
    .N(NUM_REGIONS), .PN_W(PN_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_ns(cfg_ns),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .cfg_wr_ok(cfg_wr_ok),
    .base_flat(base_flat), .size_flat(size_flat),
    .en_vec(en_vec), .sec_vec(sec_vec)
  );

  sraf_region_match #(
    .N(NUM_REGIONS), .PN_W(PN_W), .IDX_W(IDX_W)
  ) u_match (
    .page(up_addr[ADDR_W-1:PAGE_BITS]),
    .base_flat(base_flat), .size_flat(size_flat),
    .en_vec(en_vec), .sec_vec(sec_vec),
    .win_hit(win_hit), .win_idx(win_idx), .win_secure(win_secure)
  );

  sraf_perm u_perm (
    .up_req(up_req), .up_ns(up_ns),
    .win_hit(win_hit), .win_secure(win_secure),
    .fwd(acc_fwd), .blk(acc_blk)
  );

  assign mem_req    = acc_fwd;
  assign mem_addr   = up_addr;
  assign mem_write  = up_write;
  assign mem_wdata  = up_wdata;
  assign up_ack     = acc_fwd & mem_ack;
  assign up_err     = acc_blk;
  assign up_rdata   = acc_fwd ? mem_rdata : '0;
  assign unused_obs = ^{win_idx, cfg_wr_ok};

endmodule

// File: rtl/sraf_checker.sv
module sraf_checker #(
  parameter int N     = 4,
  parameter int PN_W  = 20,
  parameter int IDX_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_req,
  input logic              up_ns,
  input logic              up_err,
  input logic              up_ack,
  input logic              mem_req,
  input logic              cfg_valid,
  input logic              cfg_write,
  input logic              cfg_ns,
  input logic [N*PN_W-1:0] base_flat,
  input logic [N*PN_W-1:0] size_flat,
  input logic [N-1:0]      en_vec,
  input logic [N-1:0]      sec_vec,
  input logic              win_hit,
  input logic [IDX_W-1:0]  win_idx,
  input logic              win_secure
);

  AST_BLOCK_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    up_err |-> !mem_req && !up_ack); // R4

  AST_SECURE_REACHES_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req && !up_ns) |-> mem_req && !up_err); // R2

  AST_MEM_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> up_req); // R2

  AST_NS_FWD_NONSECURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && up_ns) |-> win_hit && !win_secure); // R3

  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> en_vec[win_idx]); // R6

  AST_NS_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_write && cfg_ns) |=>
      $stable(base_flat) && $stable(size_flat) &&
      $stable(en_vec) && $stable(sec_vec)); // R9

endmodule

bind sraf_top sraf_checker #(
  .N(NUM_REGIONS), .PN_W(PN_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .up_req(up_req), .up_ns(up_ns), .up_err(up_err), .up_ack(up_ack),
  .mem_req(mem_req),
  .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_ns(cfg_ns),
  .base_flat(base_flat), .size_flat(size_flat),
  .en_vec(en_vec), .sec_vec(sec_vec),
  .win_hit(win_hit), .win_idx(win_idx), .win_secure(win_secure)
);

// File: tb/sraf_top_tb.sv
module sraf_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam logic [31:0] RD_KEY = 32'hA5A5_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_req = 0, up_write = 0, up_ns = 0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic        up_ack, up_err, mem_req, mem_write;
  logic [31:0] up_rdata, mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack;
  logic        cfg_valid = 0, cfg_write = 0, cfg_ns = 0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        cfg_err;

  int checks = 0;
  int fails  = 0;

  // Reference region table
  longint m_base[NR];
  longint m_size[NR];
  bit     m_en[NR];
  bit     m_sec[NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_ack   = mem_req;
  assign mem_rdata = mem_addr ^ RD_KEY;

  sraf_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .up_req(up_req), .up_addr(up_addr), .up_write(up_write), .up_ns(up_ns),
    .up_wdata(up_wdata), .up_ack(up_ack), .up_err(up_err), .up_rdata(up_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_write(mem_write),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_ns(cfg_ns),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_err(cfg_err)
  );

  function automatic bit model_permit(logic [31:0] a, bit ns);
    longint pg = longint'(a >> 12);
    int win = -1;
    if (!ns) return 1'b1;
    foreach (m_en[i])
      if (m_en[i] && pg >= m_base[i] && pg < m_base[i] + m_size[i]) win = i;
    if (win < 0) return 1'b0;
    return !m_sec[win];
  endfunction

  function automatic logic [31:0] model_cfg_read();
    int i = int'(cfg_addr[3:2]);
    if (!cfg_valid) return '0;
    case (cfg_addr[1:0])
      2'd0: return 32'(m_base[i]);
      2'd1: return 32'(m_size[i]);
      2'd2: return {30'd0, m_sec[i], m_en[i]};
      default: return '0;
    endcase
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: compare every output against the model mid-cycle,
  // then update the model at the edge and clear the inputs.
  task automatic step(string tag);
    bit fwd, blk;
    @(negedge clk);
    fwd = up_req && model_permit(up_addr, up_ns);
    blk = up_req && !model_permit(up_addr, up_ns);
    cmp(tag, "mem_req", 32'(mem_req), 32'(fwd));
    cmp(tag, "up_err", 32'(up_err), 32'(blk));
    cmp(tag, "up_ack", 32'(up_ack), 32'(fwd));
    cmp(tag, "up_rdata", up_rdata, fwd ? (up_addr ^ RD_KEY) : 32'd0);
    if (fwd) begin
      cmp(tag, "mem_addr", mem_addr, up_addr);
      cmp(tag, "mem_write", 32'(mem_write), 32'(up_write));
      cmp(tag, "mem_wdata", mem_wdata, up_wdata);
    end
    cmp(tag, "cfg_err", 32'(cfg_err), 32'(cfg_valid && cfg_write && cfg_ns));
    cmp(tag, "cfg_rdata", cfg_rdata, model_cfg_read());
    @(posedge clk);
    if (cfg_valid && cfg_write && !cfg_ns) begin
      int i = int'(cfg_addr[3:2]);
      case (cfg_addr[1:0])
        2'd0: m_base[i] = longint'(cfg_wdata[19:0]);
        2'd1: m_size[i] = longint'(cfg_wdata[19:0]);
        2'd2: begin m_en[i] = cfg_wdata[0]; m_sec[i] = cfg_wdata[1]; end
        default: ;
      endcase
    end
    #1;
    up_req = 0; up_ns = 0; up_write = 0;
    cfg_valid = 0; cfg_write = 0; cfg_ns = 0;
  endtask

  task automatic acc(logic [31:0] a, bit ns, bit wr, string tag);
    up_req = 1; up_addr = a; up_ns = ns; up_write = wr; up_wdata = ~a;
    step(tag);
  endtask

  task automatic cfg_wr(int idx, int sel, logic [31:0] d, bit ns, string tag);
    cfg_valid = 1; cfg_write = 1; cfg_ns = ns;
    cfg_addr = {2'(idx), 2'(sel)}; cfg_wdata = d;
    step(tag);
  endtask

  task automatic cfg_rd(int idx, int sel, string tag);
    cfg_valid = 1; cfg_write = 0; cfg_ns = 1;
    cfg_addr = {2'(idx), 2'(sel)};
    step(tag);
  endtask

  task automatic region(int idx, int base, int size, int ctrl, string tag);
    cfg_wr(idx, 0, 32'(base), 0, tag);
    cfg_wr(idx, 1, 32'(size), 0, tag);
    cfg_wr(idx, 2, 32'(ctrl), 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    foreach (m_en[i]) begin m_base[i] = 0; m_size[i] = 0; m_en[i] = 0; m_sec[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset contents and default refusal of non-secure traffic
    for (int i = 0; i < NR; i++) begin
      cfg_rd(i, 0, "R1"); cfg_rd(i, 1, "R1"); cfg_rd(i, 2, "R1");
    end
    acc(32'h0000_1000, 1, 0, "R1");
    acc(32'h0000_1000, 0, 1, "R1");
    cfg_rd(0, 3, "R8");

    // R3/R7: region 0 non-secure, pages 0x10..0x1F
    region(0, 'h10, 'h10, 1, "R8");
    cfg_rd(0, 0, "R8"); cfg_rd(0, 1, "R8"); cfg_rd(0, 2, "R8");
    acc(32'h0001_0000, 1, 0, "R3");
    acc(32'h0001_FFFF, 1, 1, "R7");
    acc(32'h0002_0000, 1, 0, "R7");
    acc(32'h0000_FFFF, 1, 0, "R5");
    acc(32'h8000_0000, 1, 0, "R5");
    acc(32'h8000_0000, 0, 0, "R2");

    // R4/R6: region 1 secure over pages 0x18..0x1B
    region(1, 'h18, 4, 3, "R8");
    acc(32'h0001_8ABC, 1, 0, "R4");
    acc(32'h0001_C000, 1, 0, "R6");
    acc(32'h0001_8000, 0, 1, "R2");

    // R6: region 2 non-secure single page overrides region 1
    region(2, 'h18, 1, 1, "R6");
    acc(32'h0001_8004, 1, 0, "R6");
    acc(32'h0001_9000, 1, 0, "R6");

    // R6: disabled secure region 3 is ignored
    region(3, 'h18, 8, 2, "R6");
    acc(32'h0001_8000, 1, 0, "R6");

    // R7: zero-size region 3 matches nothing
    region(3, 'h10, 0, 3, "R7");
    acc(32'h0001_0000, 1, 0, "R7");

    // R9: non-secure config writes are refused and change nothing
    cfg_wr(0, 2, 32'h3, 1, "R9");
    cfg_wr(0, 0, 32'h0, 1, "R9");
    cfg_wr(1, 2, 32'h0, 1, "R9");
    cfg_rd(0, 2, "R9"); cfg_rd(0, 0, "R9"); cfg_rd(1, 2, "R9");
    acc(32'h0001_0000, 1, 0, "R9");
    acc(32'h0001_A000, 1, 0, "R9");

    // R8: secure write to reserved select has no effect
    cfg_wr(0, 3, 32'hFFFF_FFFF, 0, "R8");
    cfg_rd(0, 3, "R8"); cfg_rd(0, 2, "R8");

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule